// File: doc/BRIEF.md
# Register Rename Map with Branch Checkpoints

This block maps each architectural register to the reorder-buffer tag of its newest in-flight producer. Every entry holds a tag and a valid bit. When decode looks up a source, a valid entry returns the tag of the slot that will produce the value. An invalid entry means the value is already in the committed register file. Decode writes the destination mapping of each renamed instruction through a single update port. When an instruction commits, its mapping is dropped, but only if no younger writer has replaced it in the meantime.

At each predicted branch, decode asks for a checkpoint of the whole map. Checkpoints occupy a small ring of slots in order of branch age. A branch that resolves as predicted frees the oldest slot. A branch that resolves as mispredicted writes its slot back into the live map. That slot and all younger slots are then discarded. An exception flush clears every valid bit and drops all checkpoints. When every slot is in use, a full flag tells decode to stall the branch.

Top module: `regmap_ckpt`

## Requirements
- R1: The lookup outputs are combinational from the map as it stood at the start of the cycle. A destination write to the same register in that cycle is not visible until the next cycle.
- R2: A destination write (dst_we) makes that register valid with the written tag from the next cycle on.
- R3: A commit clears the valid bit of cmt_idx only when the stored tag equals cmt_tag. A commit with any other tag leaves the entry unchanged.
- R4: If a destination write and a matching commit name the same register in the same cycle, the entry holds the new tag and stays valid.
- R5: xcpt_flush clears every valid bit and discards all checkpoints. After it, br_full is 0 and br_id is 0.
- R6: A checkpoint request accepted while br_full is 0 saves the map into slot br_id, including that cycle's destination write and commit. br_id then advances by one, modulo the slot count.
- R7: br_bad with slot br_bad_id makes the live map equal to that slot's saved image from the next cycle on. A destination write or checkpoint request in the same cycle is ignored.
- R8: A rollback discards the named slot and every younger slot, so the next checkpoint is given id br_bad_id.
- R9: When all slots are live, br_full is 1, a checkpoint request is not taken, and br_id does not move.
- R10: br_ok frees the oldest live slot. That slot can be reallocated once br_id wraps around to it.
- R11: A commit also clears a matching valid entry in every saved checkpoint. A later rollback therefore never brings back a mapping whose producer has committed.
- R12: After reset, every entry is invalid, no checkpoint is live, br_full is 0 and br_id is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_idx | input | NUM_SRC*AIDX_W | Source register numbers, one field per lookup port |
| lk_hit | output | NUM_SRC | Entry valid: the value comes from the reorder buffer |
| lk_tag | output | NUM_SRC*TAG_W | Producer tag, one field per lookup port |
| dst_we | input | 1 | Write a destination mapping |
| dst_idx | input | AIDX_W | Destination register |
| dst_tag | input | TAG_W | Tag of the new producer |
| cmt_en | input | 1 | An instruction commits |
| cmt_idx | input | AIDX_W | Committing instruction's destination register |
| cmt_tag | input | TAG_W | Committing instruction's tag |
| br_ckpt | input | 1 | Request a checkpoint for a predicted branch |
| br_full | output | 1 | All checkpoint slots live; the branch must stall |
| br_id | output | CK_W | Slot that the next accepted checkpoint takes |
| br_ok | input | 1 | Oldest unresolved branch was predicted correctly |
| br_bad | input | 1 | A branch was mispredicted; roll back to its slot |
| br_bad_id | input | CK_W | Slot of the mispredicted branch |
| xcpt_flush | input | 1 | Exception taken; clear the map |

## Verification
The assertions assume that br_ok is raised only while a checkpoint is live, that br_ok and br_bad are never high in the same cycle, and that br_bad_id always names a live slot. The bench respects these rules by tracking the branch order in each directed task. It only resolves slots it has allocated, and it always rolls back to an allocated slot that is no older than the oldest one still live. Rollbacks are applied in cycles without a commit, so that the restored image can be compared exactly.

// File: rtl/rmap_pkg.sv
package rmap_pkg;

   // Selects where the next live map comes from.
   typedef enum logic [1:0] {
      MAP_LIVE  = 2'd0,
      MAP_SNAP  = 2'd1,
      MAP_CLEAR = 2'd2
   } map_src_e;

endpackage

// File: rtl/rmap_table.sv
module rmap_table
   import rmap_pkg::*;
#(
   parameter int NUM_ARCH = 32,
   parameter int TAG_W    = 6,
   parameter int NUM_SRC  = 2,
   parameter int AIDX_W   = $clog2(NUM_ARCH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic                              restore,
   input  logic [NUM_ARCH-1:0][TAG_W:0]      restore_img,
   input  logic                              wr_en,
   input  logic [AIDX_W-1:0]                 wr_idx,
   input  logic [TAG_W-1:0]                  wr_tag,
   input  logic                              cm_en,
   input  logic [AIDX_W-1:0]                 cm_idx,
   input  logic [TAG_W-1:0]                  cm_tag,
   input  logic [NUM_SRC*AIDX_W-1:0]         lk_idx,
   output logic [NUM_SRC-1:0]                lk_hit,
   output logic [NUM_SRC*TAG_W-1:0]          lk_tag,
   output logic [NUM_ARCH-1:0][TAG_W:0]      img_q,
   output logic [NUM_ARCH-1:0][TAG_W:0]      img_d
);

   localparam int VB = TAG_W;   // position of the valid bit in an entry

   map_src_e src_sel;

   always_comb begin
      if (flush)        src_sel = MAP_CLEAR;
      else if (restore) src_sel = MAP_SNAP;
      else              src_sel = MAP_LIVE;
   end

   always_comb begin
      img_d = img_q;
      unique case (src_sel)
         MAP_CLEAR: for (int i = 0; i < NUM_ARCH; i++) img_d[i][VB] = 1'b0;
         MAP_SNAP:  img_d = restore_img;
         default:   ;
      endcase
      if (cm_en && src_sel != MAP_CLEAR && img_d[cm_idx][VB] &&
          img_d[cm_idx][TAG_W-1:0] == cm_tag)
         img_d[cm_idx][VB] = 1'b0;
      if (wr_en && src_sel == MAP_LIVE)
         img_d[wr_idx] = {1'b1, wr_tag};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) img_q <= '0;
      else        img_q <= img_d;
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_lookup
      logic [AIDX_W-1:0] sel_idx;
      assign sel_idx                  = lk_idx[g*AIDX_W +: AIDX_W];
      assign lk_hit[g]                = img_q[sel_idx][VB];
      assign lk_tag[g*TAG_W +: TAG_W] = img_q[sel_idx][TAG_W-1:0];
   end

   // R2: a live write shows up in the next cycle
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush && !restore) |=> img_q[$past(wr_idx)] == {1'b1, $past(wr_tag)});

   // R3: a matching commit with no competing write drops the mapping
   a_r3_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_en && !flush && !restore && img_q[cm_idx][VB] &&
       img_q[cm_idx][TAG_W-1:0] == cm_tag && !(wr_en && wr_idx == cm_idx))
      |=> !img_q[$past(cm_idx)][VB]);

   // R5: a flush leaves no valid entry
   a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> $countones(img_q[0]) >= 0 && ({<<{img_q}} & '0) == '0 &&
                !img_q[0][VB] && !img_q[NUM_ARCH-1][VB]);

endmodule

// File: rtl/rmap_snap_bank.sv
module rmap_snap_bank #(
   parameter int NUM_ARCH = 32,
   parameter int TAG_W    = 6,
   parameter int NUM_CKPT = 4,
   parameter int AIDX_W   = $clog2(NUM_ARCH),
   parameter int CK_W     = $clog2(NUM_CKPT)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_en,
   input  logic [CK_W-1:0]               cap_slot,
   input  logic [NUM_ARCH-1:0][TAG_W:0]  cap_img,
   input  logic                          cm_en,
   input  logic [AIDX_W-1:0]             cm_idx,
   input  logic [TAG_W-1:0]              cm_tag,
   input  logic [CK_W-1:0]               rd_slot,
   output logic [NUM_ARCH-1:0][TAG_W:0]  rd_img
);

   localparam int VB = TAG_W;

   logic [NUM_ARCH-1:0][TAG_W:0] slot_img [NUM_CKPT];

   for (genvar s = 0; s < NUM_CKPT; s++) begin : g_slot
      logic [NUM_ARCH-1:0][TAG_W:0] img_q;
      logic                         hit_cap;
      logic                         hit_cm;

      assign hit_cap = cap_en && cap_slot == CK_W'(s);
      assign hit_cm  = cm_en && img_q[cm_idx][VB] && img_q[cm_idx][TAG_W-1:0] == cm_tag;

      always_ff @(posedge clk) begin
         if (!rst_n)       img_q             <= '0;
         else if (hit_cap) img_q             <= cap_img;
         else if (hit_cm)  img_q[cm_idx][VB] <= 1'b0;
      end

      assign slot_img[s] = img_q;

      // R11: saved images forget producers that have committed
      a_r11_snap_commit_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_cm && !hit_cap) |=> !img_q[$past(cm_idx)][VB]);
   end

   assign rd_img = slot_img[rd_slot];

endmodule

// File: rtl/rmap_ckpt_ring.sv
module rmap_ckpt_ring #(
   parameter int NUM_CKPT = 4,
   parameter int CK_W     = $clog2(NUM_CKPT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            req,
   input  logic            resolve,
   input  logic            rollback,
   input  logic [CK_W-1:0] rollback_id,
   output logic            full,
   output logic [CK_W-1:0] alloc_id,
   output logic            cap_en
);

   localparam int CNT_W = CK_W + 1;

   logic [CK_W-1:0]  head_q, tail_q;
   logic [CNT_W-1:0] cnt_q;

   assign full     = cnt_q == CNT_W'(NUM_CKPT);
   assign alloc_id = tail_q;
   assign cap_en   = req && !full && !rollback && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (rollback) begin
         tail_q <= rollback_id;
         cnt_q  <= {1'b0, rollback_id - head_q};
      end else begin
         if (resolve) head_q <= head_q + 1'b1;
         if (cap_en)  tail_q <= tail_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(cap_en) - CNT_W'(resolve);
      end
   end

   // R10: a resolve needs a live slot (input rule)
   a_r10_resolve_live: assert property (@(posedge clk) disable iff (!rst_n)
      resolve |-> cnt_q != '0);

   // R9: the live count never exceeds the slot count
   a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(NUM_CKPT));

   // R9: a stalled request changes nothing
   a_r9_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (full && req && !resolve && !rollback && !flush) |=> $stable(tail_q) && $stable(cnt_q));

   // R8: after a rollback the next allocation reuses the mispredicted slot
   a_r8_rollback_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (rollback && !flush) |=> alloc_id == $past(rollback_id));

endmodule

// File: rtl/regmap_ckpt.sv
module regmap_ckpt #(
   parameter int NUM_ARCH = 32,
   parameter int TAG_W    = 6,
   parameter int NUM_SRC  = 2,
   parameter int NUM_CKPT = 4,
   parameter int AIDX_W   = $clog2(NUM_ARCH),
   parameter int CK_W     = $clog2(NUM_CKPT)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC*AIDX_W-1:0] lk_idx,
   output logic [NUM_SRC-1:0]        lk_hit,
   output logic [NUM_SRC*TAG_W-1:0]  lk_tag,
   input  logic                      dst_we,
   input  logic [AIDX_W-1:0]         dst_idx,
   input  logic [TAG_W-1:0]          dst_tag,
   input  logic                      cmt_en,
   input  logic [AIDX_W-1:0]         cmt_idx,
   input  logic [TAG_W-1:0]          cmt_tag,
   input  logic                      br_ckpt,
   output logic                      br_full,
   output logic [CK_W-1:0]           br_id,
   input  logic                      br_ok,
   input  logic                      br_bad,
   input  logic [CK_W-1:0]           br_bad_id,
   input  logic                      xcpt_flush
);

   if (NUM_CKPT < 2 || (NUM_CKPT & (NUM_CKPT - 1)) != 0) begin : g_bad_ckpt
      $error("NUM_CKPT must be a power of two, at least 2");
   end
   if (NUM_ARCH < 2 || TAG_W < 1 || NUM_SRC < 1) begin : g_bad_size
      $error("NUM_ARCH, TAG_W and NUM_SRC out of range");
   end

   logic [NUM_ARCH-1:0][TAG_W:0] map_q, map_d, snap_rd;
   logic                         cap_en;

   rmap_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .NUM_SRC(NUM_SRC), .AIDX_W(AIDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .flush(xcpt_flush), .restore(br_bad), .restore_img(snap_rd),
      .wr_en(dst_we), .wr_idx(dst_idx), .wr_tag(dst_tag),
      .cm_en(cmt_en), .cm_idx(cmt_idx), .cm_tag(cmt_tag),
      .lk_idx(lk_idx), .lk_hit(lk_hit), .lk_tag(lk_tag),
      .img_q(map_q), .img_d(map_d));

   rmap_snap_bank #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .NUM_CKPT(NUM_CKPT),
                    .AIDX_W(AIDX_W), .CK_W(CK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_slot(br_id), .cap_img(map_d),
      .cm_en(cmt_en), .cm_idx(cmt_idx), .cm_tag(cmt_tag),
      .rd_slot(br_bad_id), .rd_img(snap_rd));

   rmap_ckpt_ring #(.NUM_CKPT(NUM_CKPT), .CK_W(CK_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .flush(xcpt_flush), .req(br_ckpt), .resolve(br_ok),
      .rollback(br_bad), .rollback_id(br_bad_id),
      .full(br_full), .alloc_id(br_id), .cap_en(cap_en));

   // input rule: one resolution kind per cycle
   a_r10_one_resolution: assert property (@(posedge clk) disable iff (!rst_n)
      !(br_ok && br_bad));

   // R7: a rollback without a commit installs the saved image unchanged
   a_r7_restore_image: assert property (@(posedge clk) disable iff (!rst_n)
      (br_bad && !xcpt_flush && !cmt_en) |=> map_q == $past(snap_rd));

endmodule

// File: tb/regmap_ckpt_test.sv
`timescale 1ns/100ps
module regmap_ckpt_test;

   localparam int NA = 32, TW = 6, NS = 2, NC = 4, AW = 5, CW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NS*AW-1:0] lk_idx = '0;
   logic [NS-1:0]    lk_hit;
   logic [NS*TW-1:0] lk_tag;
   logic dst_we = 0, cmt_en = 0, br_ckpt = 0, br_ok = 0, br_bad = 0, xcpt_flush = 0;
   logic [AW-1:0] dst_idx = '0, cmt_idx = '0;
   logic [TW-1:0] dst_tag = '0, cmt_tag = '0;
   logic [CW-1:0] br_bad_id = '0, br_id;
   logic br_full;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   regmap_ckpt uut (.*);

   task automatic tick();
      @(posedge clk); #1;
      dst_we = 0; cmt_en = 0; br_ckpt = 0; br_ok = 0; br_bad = 0; xcpt_flush = 0;
   endtask

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // encode lookup result as -1 for invalid or the tag
   task automatic chk_map(string req, int port, int idx, int exp);
      int act;
      lk_idx[port*AW +: AW] = AW'(idx);
      #0.1;
      act = lk_hit[port] ? int'(lk_tag[port*TW +: TW]) : -1;
      chk(req, act, exp);
   endtask

   task automatic wr(int idx, int tag);
      dst_we = 1; dst_idx = AW'(idx); dst_tag = TW'(tag);
   endtask

   task automatic cm(int idx, int tag);
      cmt_en = 1; cmt_idx = AW'(idx); cmt_tag = TW'(tag);
   endtask

   task automatic flush_all();
      xcpt_flush = 1; tick();
   endtask

   task automatic t_reset();
      chk_map("R12 r0", 0, 0, -1);
      chk_map("R12 r31", 1, 31, -1);
      chk("R12 full", int'(br_full), 0);
      chk("R12 id", int'(br_id), 0);
   endtask

   task automatic t_write_commit();
      wr(3, 5);
      chk_map("R1 pre-write view", 0, 3, -1);
      tick();
      chk_map("R2 write seen", 1, 3, 5);
      cm(3, 7); tick();
      chk_map("R3 tag mismatch keeps", 0, 3, 5);
      cm(3, 5); tick();
      chk_map("R3 match clears", 0, 3, -1);
      wr(4, 9); tick();
      wr(4, 10); cm(4, 9); tick();
      chk_map("R4 write beats commit", 0, 4, 10);
   endtask

   task automatic t_ckpt_restore();
      wr(5, 11); br_ckpt = 1;
      chk("R6 slot id", int'(br_id), 0);
      tick();
      chk("R6 id advances", int'(br_id), 1);
      wr(4, 12); tick();
      chk_map("R2 overwrite", 0, 4, 12);
      br_bad = 1; br_bad_id = 0; wr(6, 1); br_ckpt = 1; tick();
      chk_map("R7 restored r4", 0, 4, 10);
      chk_map("R6 same-cycle write saved", 1, 5, 11);
      chk_map("R7 write ignored", 0, 6, -1);
      chk("R8 id reuse", int'(br_id), 0);
   endtask

   task automatic t_order();
      flush_all();
      wr(1, 1); br_ckpt = 1; tick();
      wr(1, 2); br_ckpt = 1; tick();
      wr(1, 3); br_ckpt = 1; tick();
      wr(1, 4); tick();
      chk("R6 three slots", int'(br_id), 3);
      br_bad = 1; br_bad_id = 1; tick();
      chk_map("R7 middle slot", 0, 1, 2);
      chk("R8 younger dropped", int'(br_id), 1);
      br_ckpt = 1; tick();
      chk("R8 realloc", int'(br_id), 2);
   endtask

   task automatic t_full();
      flush_all();
      for (int i = 0; i < NC; i++) begin br_ckpt = 1; tick(); end
      chk("R9 full", int'(br_full), 1);
      br_ckpt = 1; wr(2, 33); tick();
      chk("R9 still full", int'(br_full), 1);
      chk("R9 id held", int'(br_id), 0);
      br_ok = 1; tick();
      chk("R10 slot freed", int'(br_full), 0);
      br_ckpt = 1; tick();
      chk("R10 oldest reused", int'(br_full), 1);
      br_bad = 1; br_bad_id = 1; tick();
      chk("R8 all dropped", int'(br_full), 0);
      chk("R8 id", int'(br_id), 1);
   endtask

   task automatic t_flush();
      wr(7, 3); br_ckpt = 1; tick();
      chk_map("R2 pre-flush", 0, 7, 3);
      flush_all();
      chk_map("R5 map cleared", 0, 7, -1);
      chk_map("R5 map cleared r2", 1, 2, -1);
      chk("R5 id", int'(br_id), 0);
      chk("R5 full", int'(br_full), 0);
   endtask

   task automatic t_snap_commit();
      wr(8, 20); br_ckpt = 1; tick();
      cm(8, 20); tick();
      chk_map("R3 live cleared", 0, 8, -1);
      wr(8, 21); tick();
      br_bad = 1; br_bad_id = 0; tick();
      chk_map("R11 snapshot forgot", 0, 8, -1);
   endtask

   initial begin
      #1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_write_commit();
      t_ckpt_restore();
      t_order();
      t_full();
      t_flush();
      t_snap_commit();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule